// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer Core

This block is a watchdog counter that advances on a slow working clock delivered as a one-cycle enable strobe in the fast system clock domain. Software picks a power-of-two period through a select field. When the count runs out, the block raises a timeout flag and a wake flag, and drives an interrupt line if the interrupt is enabled. It also opens a grace window of a fixed number of working-clock ticks. If software does not clear the counter before that window ends, the block emits a one-cycle system reset pulse and records the cause in a sticky flag.

The control inputs are write strobes: one loads the enable bit, one loads the period select and the interrupt enable, one clears the counter, and three clear individual flags by writing 1. The sticky reset-cause flag sits on a separate power-on reset. The system reset that the pulse triggers therefore leaves it intact, and software can read it after reboot.

Top module: `wdt_core`

## Requirements
- R1: While `rstN` is low, the outputs `irq`, `rstPulse`, `timeoutFlag` and `wakeFlag` read 0, the block is disabled and the count is zero. `rstFlag` reads 0 only after `porN` has been low.
- R2: With the block enabled, the counter advances only on cycles where `tickEn` is high. Period select s (0..8) gives a timeout on the 2^(4+2*s)-th counted tick: 16 for s=0, 64 for s=1, up to 1048576 for s=8. Values above 8 act as 8. On that tick the counter restarts from zero and `timeoutFlag` reads 1 from the following cycle.
- R3: `irq` is high exactly while `timeoutFlag` is set and the stored interrupt enable is 1.
- R4: Once a timeout has opened the grace window, the 1026th counted tick after it produces `rstPulse` high for exactly one cycle. A timeout that falls inside an open window does not restart the window.
- R5: A `cntClr` strobe restarts the count from zero and closes any open grace window. A tick in the same cycle as the strobe is not counted.
- R6: `wakeFlag` is set on the same tick as `timeoutFlag`. Each flag is cleared only by its own write-1 strobe (`clrTimeoutFlag`, `clrWakeFlag`). If a set and a clear arrive together, the set wins.
- R7: The `rstPulse` tick sets `rstFlag`. `rstFlag` survives `rstN` and is cleared only by `clrRstFlag` or `porN`.
- R8: An `enWr` strobe with `enVal`=0 freezes both the count and the grace window. A later `enWr` with `enVal`=1 resumes both from where they stopped.
- R9: A `cfgWr` strobe loads the period select and the interrupt enable, restarts the count from zero and closes the grace window. A tick in the same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| porN | input | 1 | Active-low power-on reset for the reset-cause flag |
| tickEn | input | 1 | Working-clock enable strobe |
| enWr | input | 1 | Write strobe for the enable bit |
| enVal | input | 1 | Enable value loaded by `enWr` |
| cfgWr | input | 1 | Write strobe for period select and interrupt enable |
| cfgSel | input | SEL_W | Period select loaded by `cfgWr` |
| cfgIntEn | input | 1 | Interrupt enable loaded by `cfgWr` |
| cntClr | input | 1 | Counter clear strobe |
| clrTimeoutFlag | input | 1 | Write-1 clear of the timeout flag |
| clrWakeFlag | input | 1 | Write-1 clear of the wake flag |
| clrRstFlag | input | 1 | Write-1 clear of the reset-cause flag |
| irq | output | 1 | Timeout interrupt |
| rstPulse | output | 1 | One-cycle system reset request |
| timeoutFlag | output | 1 | Sticky timeout flag |
| wakeFlag | output | 1 | Sticky wake flag |
| rstFlag | output | 1 | Sticky reset-cause flag |

## Verification
Every output is a register. A tick accepted on one clock edge shows up in the flags, in `irq` and in `rstPulse` on the next edge and no later. A clear strobe takes effect on the edge that samples it. The bench drives inputs and samples outputs on the falling edge. Its behavioural model advances on the rising edge, so each comparison sees the state one edge after the stimulus. Directed counts then confirm the exact intervals: 16 and 64 ticks to timeout, 1026 ticks of grace, and 1042 ticks from a clear to the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the control to the datapath, one edge each.
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic graceStart;
    logic graceInc;
    logic graceStop;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int MAX_SEL     = 8,
  parameter int GRACE_TICKS = 1026,
  localparam int CNT_W      = 4 + 2 * MAX_SEL,
  localparam int GR_W       = $clog2(GRACE_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobes_t      strobes,
  input  logic [SEL_W-1:0] sel,
  output logic             periodHit,
  output logic             graceActive,
  output logic             graceHit
);
  logic [CNT_W-1:0] count;
  logic [GR_W-1:0]  graceCnt;
  logic [SEL_W-1:0] selEff;
  logic [CNT_W:0]   periodLen;
  logic [CNT_W-1:0] lastCount;

  // Select values above the limit behave as the limit.
  assign selEff    = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
  assign periodLen = (CNT_W+1)'(1) << (4 + 2 * int'(selEff));
  assign lastCount = CNT_W'(periodLen - (CNT_W+1)'(1));
  assign periodHit = (count == lastCount);
  assign graceHit  = graceActive && (graceCnt == GR_W'(GRACE_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strobes.cntClr)  count <= '0;
    else if (strobes.cntInc)  count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graceActive <= 1'b0;
      graceCnt    <= '0;
    end else if (strobes.graceStop) begin
      graceActive <= 1'b0;
      graceCnt    <= '0;
    end else if (strobes.graceStart) begin
      graceActive <= 1'b1;
      graceCnt    <= '0;
    end else if (strobes.graceInc) begin
      graceCnt    <= graceCnt + 1'b1;
    end
  end

  // R5, R9: a clear from the control leaves the count at zero.
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClr |=> (count == '0));
  // R8: with no increment and no clear the count holds.
  p_hold_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntInc && !strobes.cntClr) |=> $stable(count));
  // R8: with no grace strobe the grace counter holds.
  p_hold_grace_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.graceInc && !strobes.graceStop && !strobes.graceStart) |=> $stable(graceCnt));
  // R2: the count never passes the last value of the selected period.
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= lastCount);
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             tickEn,
  input  logic             enWr,
  input  logic             enVal,
  input  logic             cfgWr,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             cfgIntEn,
  input  logic             cntClrIn,
  input  logic             clrTimeoutFlag,
  input  logic             clrWakeFlag,
  input  logic             clrRstFlag,
  input  logic             periodHit,
  input  logic             graceActive,
  input  logic             graceHit,
  output wdtStrobes_t      strobes,
  output logic [SEL_W-1:0] selReg,
  output logic             irq,
  output logic             rstPulse,
  output logic             timeoutFlag,
  output logic             wakeFlag,
  output logic             rstFlag
);
  logic enable;
  logic intEn;
  logic tickGo;
  logic hitNow;
  logic fireNow;
  logic anyClr;

  assign anyClr  = cntClrIn | cfgWr;
  assign tickGo  = tickEn & enable & ~anyClr;
  assign hitNow  = tickGo & periodHit;
  assign fireNow = tickGo & graceHit;

  always_comb begin
    strobes.cntClr     = anyClr | hitNow;
    strobes.cntInc     = tickGo;
    strobes.graceStop  = anyClr | fireNow;
    strobes.graceStart = hitNow & ~graceActive;
    strobes.graceInc   = tickGo & graceActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable      <= 1'b0;
      intEn       <= 1'b0;
      selReg      <= '0;
      timeoutFlag <= 1'b0;
      wakeFlag    <= 1'b0;
      rstPulse    <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (enWr) enable <= enVal;
      if (cfgWr) begin
        selReg <= cfgSel;
        intEn  <= cfgIntEn;
      end
      if (hitNow)              timeoutFlag <= 1'b1;
      else if (clrTimeoutFlag) timeoutFlag <= 1'b0;
      if (hitNow)              wakeFlag <= 1'b1;
      else if (clrWakeFlag)    wakeFlag <= 1'b0;
      rstPulse <= fireNow;
      irq      <= (hitNow | (timeoutFlag & ~clrTimeoutFlag)) & (cfgWr ? cfgIntEn : intEn);
    end
  end

  // Reset-cause flag lives on the power-on domain.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           rstFlag <= 1'b0;
    else if (fireNow)    rstFlag <= 1'b1;
    else if (clrRstFlag) rstFlag <= 1'b0;
  end

  // R4: the reset request lasts one cycle.
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse);
  // R4: a reset request only follows an open grace window.
  p_pulse_from_grace_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> $past(graceActive));
  // R2, R6: a period hit sets both flags.
  p_timeout_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> (timeoutFlag && wakeFlag));
  // R7: a reset request is always recorded.
  p_cause_recorded_r7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    rstPulse |-> rstFlag);
  // R3: the interrupt never rises without the flag.
  p_irq_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> timeoutFlag);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int MAX_SEL     = 8,
  parameter int GRACE_TICKS = 1026
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             tickEn,
  input  logic             enWr,
  input  logic             enVal,
  input  logic             cfgWr,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             cfgIntEn,
  input  logic             cntClr,
  input  logic             clrTimeoutFlag,
  input  logic             clrWakeFlag,
  input  logic             clrRstFlag,
  output logic             irq,
  output logic             rstPulse,
  output logic             timeoutFlag,
  output logic             wakeFlag,
  output logic             rstFlag
);
  wdtStrobes_t      strobes;
  logic [SEL_W-1:0] selReg;
  logic             periodHit;
  logic             graceActive;
  logic             graceHit;

  wdt_control #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .porN(porN), .tickEn(tickEn),
    .enWr(enWr), .enVal(enVal), .cfgWr(cfgWr), .cfgSel(cfgSel),
    .cfgIntEn(cfgIntEn), .cntClrIn(cntClr),
    .clrTimeoutFlag(clrTimeoutFlag), .clrWakeFlag(clrWakeFlag),
    .clrRstFlag(clrRstFlag), .periodHit(periodHit),
    .graceActive(graceActive), .graceHit(graceHit),
    .strobes(strobes), .selReg(selReg), .irq(irq), .rstPulse(rstPulse),
    .timeoutFlag(timeoutFlag), .wakeFlag(wakeFlag), .rstFlag(rstFlag)
  );

  wdt_datapath #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .GRACE_TICKS(GRACE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sel(selReg),
    .periodHit(periodHit), .graceActive(graceActive), .graceHit(graceHit)
  );
endmodule

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GRACE = 1026;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0, porN = 1'b0;
  logic tickEn = 1'b0, enWr = 1'b0, enVal = 1'b0, cfgWr = 1'b0, cfgIntEn = 1'b0;
  logic [3:0] cfgSel = '0;
  logic cntClr = 1'b0, clrTimeoutFlag = 1'b0, clrWakeFlag = 1'b0, clrRstFlag = 1'b0;
  logic irq, rstPulse, timeoutFlag, wakeFlag, rstFlag;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  // Behavioural model state
  int mCnt = 0, mGCnt = 0, mSel = 0;
  bit mEn = 0, mIe = 0, mGAct = 0, mT = 0, mW = 0, mRf = 0, mPulse = 0;
  bit go, hitP, hitG, fire, setT;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_core u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .tickEn(tickEn), .enWr(enWr), .enVal(enVal),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgIntEn(cfgIntEn), .cntClr(cntClr),
    .clrTimeoutFlag(clrTimeoutFlag), .clrWakeFlag(clrWakeFlag), .clrRstFlag(clrRstFlag),
    .irq(irq), .rstPulse(rstPulse), .timeoutFlag(timeoutFlag), .wakeFlag(wakeFlag),
    .rstFlag(rstFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Reference model, advanced on the active edge from the inputs alone.
  always @(posedge clk) begin
    fire = 0; setT = 0;
    if (rstN) begin
      go = tickEn && mEn && !cntClr && !cfgWr;
      if (cfgWr || cntClr) begin
        mCnt = 0; mGAct = 0; mGCnt = 0;
      end else if (go) begin
        hitG = mGAct && (mGCnt == GRACE - 1);
        hitP = (mCnt == (1 << (4 + 2 * mSel)) - 1);
        if (hitG) begin fire = 1; mGAct = 0; mGCnt = 0; end
        else if (mGAct) mGCnt++;
        else if (hitP) begin mGAct = 1; mGCnt = 0; end
        if (hitP) begin mCnt = 0; setT = 1; end
        else mCnt++;
      end
      mT = setT ? 1'b1 : (clrTimeoutFlag ? 1'b0 : mT);
      mW = setT ? 1'b1 : (clrWakeFlag ? 1'b0 : mW);
      mPulse = fire;
      if (enWr) mEn = enVal;
      if (cfgWr) begin mSel = int'(cfgSel); mIe = cfgIntEn; end
    end else begin
      mCnt = 0; mGCnt = 0; mSel = 0; mEn = 0; mIe = 0; mGAct = 0;
      mT = 0; mW = 0; mPulse = 0;
    end
    if (!porN) mRf = 0;
    else if (fire) mRf = 1;
    else if (clrRstFlag) mRf = 0;
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (porN) begin
      check(timeoutFlag == mT, "R2 timeoutFlag", timeoutFlag, mT);
      check(wakeFlag == mW, "R6 wakeFlag", wakeFlag, mW);
      check(irq == (mT && mIe), "R3 irq", irq, mT && mIe);
      check(rstPulse == mPulse, "R4 rstPulse", rstPulse, mPulse);
      check(rstFlag == mRf, "R7 rstFlag", rstFlag, mRf);
    end
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG_CYCLES);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input int sel, input bit ie);
    cfgWr = 1; cfgSel = 4'(sel); cfgIntEn = ie;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic writeEn(input bit v);
    enWr = 1; enVal = v;
    @(negedge clk); enWr = 0;
  endtask

  task automatic countUntilTimeout(output int n);
    n = 0;
    while (!timeoutFlag && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic countUntilPulse(output int n);
    n = 0;
    while (!rstPulse && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    idle(3);
    // R1: reset state
    check(irq == 0 && rstPulse == 0, "R1 outputs in reset", {irq, rstPulse}, 0);
    check(timeoutFlag == 0 && wakeFlag == 0 && rstFlag == 0, "R1 flags in reset",
          {timeoutFlag, wakeFlag, rstFlag}, 0);
    porN = 1; rstN = 1;
    idle(2);

    // R2 / R3 / R4: period 16 then 1026 grace ticks
    tickEn = 1;
    enWr = 1; enVal = 1;
    writeCfg(0, 1);
    enWr = 0;
    countUntilTimeout(n);
    check(n == 16, "R2 ticks to timeout sel=0", n, 16);
    check(irq == 1, "R3 irq with enable", irq, 1);
    countUntilPulse(n);
    check(n == GRACE, "R4 grace length", n, GRACE);
    @(negedge clk);
    check(rstPulse == 0, "R4 pulse one cycle", rstPulse, 0);
    check(rstFlag == 1, "R7 cause recorded", rstFlag, 1);

    // R6: independent write-1 clears
    tickEn = 0;
    clrWakeFlag = 1; @(negedge clk); clrWakeFlag = 0;
    check(wakeFlag == 0 && timeoutFlag == 1, "R6 wake cleared alone", {wakeFlag, timeoutFlag}, 1);
    clrTimeoutFlag = 1; @(negedge clk); clrTimeoutFlag = 0;
    check(timeoutFlag == 0 && irq == 0, "R6 timeout cleared", {timeoutFlag, irq}, 0);

    // R7: cause flag survives the system reset
    rstN = 0; idle(3); rstN = 1; idle(1);
    check(rstFlag == 1, "R7 survives rstN", rstFlag, 1);
    clrRstFlag = 1; @(negedge clk); clrRstFlag = 0;
    check(rstFlag == 0, "R7 write-1 clear", rstFlag, 0);

    // R8: pause and resume, sel=1 (64 ticks)
    writeEn(1);
    writeCfg(1, 0);
    tickEn = 1; idle(30); tickEn = 0;
    writeEn(0);
    tickEn = 1; idle(100);
    check(timeoutFlag == 0, "R8 no timeout while disabled", timeoutFlag, 0);
    writeEn(1);
    countUntilTimeout(n);
    check(n == 34, "R8 resume keeps count", n, 34);
    check(irq == 0, "R3 irq masked", irq, 1'b0);

    // R9: config write restarts count
    clrTimeoutFlag = 1; @(negedge clk); clrTimeoutFlag = 0;
    idle(10);
    writeCfg(0, 1);
    countUntilTimeout(n);
    check(n == 16, "R9 cfg write restarts count", n, 16);

    // R5: clear inside the grace window postpones the pulse
    idle(500);
    cntClr = 1; @(negedge clk); cntClr = 0;
    countUntilPulse(n);
    check(n == 16 + GRACE, "R5 clear cancels grace", n, 16 + GRACE);

    // Mixed traffic against the model
    for (int i = 0; i < 40000; i++) begin
      tickEn = ($urandom_range(0, 3) != 0);
      cntClr = ($urandom_range(0, 699) == 0);
      cfgWr  = ($urandom_range(0, 2999) == 0);
      cfgSel = 4'($urandom_range(0, 2));
      cfgIntEn = $urandom_range(0, 1);
      enWr = ($urandom_range(0, 1999) == 0);
      enVal = ($urandom_range(0, 3) != 0);
      clrTimeoutFlag = ($urandom_range(0, 199) == 0);
      clrWakeFlag = ($urandom_range(0, 199) == 0);
      clrRstFlag = ($urandom_range(0, 999) == 0);
      @(negedge clk);
    end
    {tickEn, cntClr, cfgWr, enWr, clrTimeoutFlag, clrWakeFlag, clrRstFlag} = '0;
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule